// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a one-shot countdown timer for a local interrupt controller. Software sets a divide ratio, then writes a 32-bit start value. The counter then steps down by one each time a divided tick occurs. A divided tick is a fixed base period of 16 clocks, repeated as many times as the divide ratio. When the count reaches zero, the block raises a single-clock expiry pulse. That pulse is meant to feed the timer entry of a local vector table. After the pulse the counter rests at zero until the next start value is written.

There is one write port and one combinational read port. Each selects one of three registers through a 2-bit address: divide configuration, start value, and the live remaining count. The prescaler runs freely from reset. A start value written in the middle of a base period therefore discards the partial period, so every count spans whole periods.

Top module: `tmr_countdown`

## Requirements
- R1: The divide ratio is 2^(({cfg[3],cfg[1:0]} + 1) mod 8). Configuration 0x0 gives 2, 0x1 gives 4, 0x3 gives 16, 0x8 gives 32, 0xA gives 128 and 0xB gives 1.
- R2: A write to the configuration register (address 0) keeps only bits 3, 1 and 0. A read returns zero in every other bit.
- R3: The count drops by one every 16 × ratio clocks once counting has started.
- R4: The remaining-count register (address 2) cannot be written. A write to it leaves the count and the expiry timing unchanged.
- R5: A write to the start register (address 1) takes all 32 bits. It reads back unchanged, sets the remaining count to that value on the same edge, and restarts any countdown already in progress.
- R6: The prescaler counts 16 clocks per base period, starting from reset. A start write on the edge that closes a base period (edge number k after reset with k mod 16 = 0) begins a full period at once. A start write on any other edge discards the rest of the current period.
- R7: A read of address 2 returns the number of divided ticks still remaining.
- R8: Writing a start value of zero stops the timer. No expiry pulse follows and the count stays at zero.
- R9: A configuration change during a countdown takes effect from the next divided tick onward. The divided tick already in progress keeps the old ratio.
- R10: The expiry pulse is high for exactly one clock, in the cycle after the edge on which the count steps from 1 to 0. The count then holds at zero.
- R11: After reset, all registers read zero and the expiry output is low. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select (0 config, 1 start, 2 remaining) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| expire_o | output | 1 | One-clock expiry pulse |

## Verification
A wrong prescaler phase or a wrong divider limit moves the expiry pulse by a whole number of clocks. A scoreboard that holds the expected expiry edge for each start write catches the shift on the first expiry, at least 16 clocks after the write. A wrong remaining count appears on the next read of address 2, and it is read at known edge offsets after a write. A lost stop or a lost restart shows up as an unexpected pulse or a missing pulse, detected within one cycle of the edge where the pulse was due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_DATA_W   = 32;
    localparam int TMR_BASE_DIV = 16;
    localparam int TMR_LOG_W    = 3;
    localparam logic [3:0] TMR_CFG_KEEP = 4'hB;

    typedef enum logic [1:0] {
        TMR_REG_CFG   = 2'd0,
        TMR_REG_START = 2'd1,
        TMR_REG_LEFT  = 2'd2,
        TMR_REG_NONE  = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic                  load;
        logic [TMR_DATA_W-1:0] value;
    } tmr_load_t;

    // Ratio exponent: non-contiguous 3-bit code, plus one, wrapping mod 8.
    function automatic logic [TMR_LOG_W-1:0] tmr_ratio_log(input logic [3:0] cfg);
        logic [TMR_LOG_W-1:0] code;
        code = {cfg[3], cfg[1:0]};
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int BASE_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic base_tick
);
    localparam int PW = $clog2(BASE_DIV);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (phase_q == PW'(BASE_DIV - 1))
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign base_tick = (phase_q == PW'(BASE_DIV - 1));
endmodule

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int LOG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             base_tick,
    input  logic [LOG_W-1:0] cfg_log,
    output logic             div_tick
);
    localparam int CW = (1 << LOG_W) - 1;

    logic [LOG_W-1:0] log_q;
    logic [CW-1:0]    sub_q;
    logic [CW-1:0]    limit;
    logic             skip_q;

    assign limit    = {CW{1'b1}} >> (LOG_W'(CW) - log_q);
    assign div_tick = base_tick && !skip_q && !load && (sub_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            log_q  <= '0;
            sub_q  <= '0;
            skip_q <= 1'b0;
        end else if (load) begin
            log_q  <= cfg_log;
            sub_q  <= '0;
            skip_q <= !base_tick;
        end else if (base_tick) begin
            if (skip_q) begin
                skip_q <= 1'b0;
            end else if (sub_q == limit) begin
                sub_q <= '0;
                log_q <= cfg_log;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int DATA_W = TMR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_load_t         ld,
    input  logic              div_tick,
    output logic [DATA_W-1:0] left,
    output logic              expire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            left   <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (ld.load) begin
                left <= ld.value;
            end else if (div_tick && left != '0) begin
                left   <= left - 1'b1;
                expire <= (left == DATA_W'(1));
            end
        end
    end
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
    import tmr_pkg::*;
#(
    parameter int DATA_W   = TMR_DATA_W,
    parameter int BASE_DIV = TMR_BASE_DIV,
    parameter int LOG_W    = TMR_LOG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              expire_o
);
    logic [3:0]        cfg_q;
    logic [DATA_W-1:0] start_q;
    logic [DATA_W-1:0] left;
    logic              base_tick;
    logic              div_tick;
    tmr_load_t         ld;

    assign ld.load  = wr_en && (tmr_reg_e'(wr_addr) == TMR_REG_START);
    assign ld.value = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            start_q <= '0;
        end else if (wr_en) begin
            if (tmr_reg_e'(wr_addr) == TMR_REG_CFG)
                cfg_q <= wr_data[3:0] & TMR_CFG_KEEP;
            if (ld.load)
                start_q <= wr_data;
        end
    end

    tmr_prescale #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick)
    );

    tmr_divider #(.LOG_W(LOG_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (ld.load),
        .base_tick (base_tick),
        .cfg_log   (tmr_ratio_log(cfg_q)),
        .div_tick  (div_tick)
    );

    tmr_count #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld),
        .div_tick (div_tick),
        .left     (left),
        .expire   (expire_o)
    );

    always_comb begin
        unique case (tmr_reg_e'(rd_addr))
            TMR_REG_CFG:   rd_data = {{(DATA_W-4){1'b0}}, cfg_q};
            TMR_REG_START: rd_data = start_q;
            TMR_REG_LEFT:  rd_data = left;
            default:       rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_countdown_chk.sv
module tmr_countdown_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              expire_o,
    input logic [DATA_W-1:0] left,
    input logic              load
);
    AST_CFG_MASKED: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 2'd0) |-> (rd_data[DATA_W-1:4] == '0 && rd_data[2] == 1'b0)); // R2

    AST_LEFT_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2 && !load) |=> (left == $past(left) || left == $past(left) - 1'b1)); // R4

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        load |=> (left == $past(wr_data))); // R5

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !load |=> (left == $past(left) || left == $past(left) - 1'b1)); // R3

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (left == '0 && !load) |=> (left == '0 && !expire_o)); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o); // R10

    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> (left == '0 && $past(left) == DATA_W'(1))); // R10
endmodule

bind tmr_countdown tmr_countdown_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .expire_o (expire_o),
    .left     (left),
    .load     (ld.load)
);

// File: tb/tb_tmr_countdown.sv
module tb_tmr_countdown;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        expire_o;

    always #10 clk = ~clk;

    tmr_countdown dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .expire_o(expire_o)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    timeout = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    logic  prev_exp = 1'b0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    initial begin
        repeat (200000) @(posedge clk);
        timeout = 1'b1;
    end

    // Scoreboard monitor: each pulse must match the oldest expected edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (expire_o) begin
                n_chk++;
                if (prev_exp) begin
                    n_bad++;
                    $display("FAIL R10: pulse lasted two cycles at edge %0d (actual 1, expected 0)", cyc);
                end else if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8: unexpected pulse at edge %0d (actual 1, expected 0)", cyc);
                end else begin
                    if (exp_q[0] != cyc) begin
                        n_bad++;
                        $display("FAIL %s: pulse at edge %0d, expected %0d", tag_q[0], cyc, exp_q[0]);
                    end
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
                n_chk++;
                n_bad++;
                $display("FAIL %s: no pulse by edge %0d, expected %0d", tag_q[0], cyc, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            prev_exp = expire_o;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        w = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic align(input int p);
        while (cyc % 16 != p && !timeout) @(negedge clk);
    endtask

    task automatic wait_edge(input int e);
        while (cyc < e && !timeout) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() > 0 && !timeout) @(negedge clk);
        @(negedge clk);
    endtask

    // Expected expiry edge per R3/R6.
    function automatic int exp_edge(input int w, input int n, input int r);
        int p;
        p = (w - 1) % 16;
        return w + ((p == 15) ? 0 : (15 - p)) + 16 * r * n;
    endfunction

    task automatic push(input int e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin
        logic [31:0] v;
        int w;
        int w2;
        logic [3:0] cfgs[6]   = '{4'h0, 4'h1, 4'h3, 4'h8, 4'hA, 4'hB};
        int         ratios[6] = '{2, 4, 16, 32, 128, 1};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state and unused address
        rd(2'd0, v); chk("R11", v, 32'h0);
        rd(2'd1, v); chk("R11", v, 32'h0);
        rd(2'd2, v); chk("R11", v, 32'h0);
        rd(2'd3, v); chk("R11", v, 32'h0);
        chk("R11", {31'h0, expire_o}, 32'h0);

        // R2: configuration masking
        wr(2'd0, 32'hFFFF_FFFF, w);
        rd(2'd0, v); chk("R2", v, 32'h0000_000B);
        wr(2'd0, 32'h0000_0074, w);
        rd(2'd0, v); chk("R2", v, 32'h0000_0000);

        // R1/R3/R6: each ratio, varied phase
        for (int i = 0; i < 6; i++) begin
            wr(2'd0, {28'h0, cfgs[i]}, w);
            align((i * 5 + 3) % 16);
            wr(2'd1, 32'd2, w);
            push(exp_edge(w, 2, ratios[i]), "R1");
            drain();
            rd(2'd2, v); chk("R10", v, 32'h0);
        end

        // R6: aligned start, ratio 1
        wr(2'd0, 32'hB, w);
        align(15);
        wr(2'd1, 32'd3, w);
        push(w + 48, "R6");
        drain();

        // R7/R4/R8: remaining count, ignored write, stop
        align(15);
        wr(2'd1, 32'd10, w);
        wait_edge(w + 49);
        rd(2'd2, v); chk("R7", v, 32'd7);
        wr(2'd2, 32'h0000_1234, w2);
        rd(2'd2, v); chk("R4", v, 32'd7);
        wr(2'd1, 32'd0, w2);
        rd(2'd2, v); chk("R8", v, 32'd0);
        repeat (300) @(negedge clk);
        rd(2'd2, v); chk("R8", v, 32'd0);

        // R4: write to remaining count does not move an expiry
        align(15);
        wr(2'd1, 32'd2, w);
        push(w + 32, "R4");
        wr(2'd2, 32'hFFFF_FFFF, w2);
        drain();

        // R5: full-width load, read back, restart mid-run
        wr(2'd1, 32'hDEAD_BEEF, w);
        rd(2'd1, v); chk("R5", v, 32'hDEAD_BEEF);
        rd(2'd2, v); chk("R5", v, 32'hDEAD_BEEF);
        repeat (40) @(negedge clk);
        align(6);
        wr(2'd1, 32'd2, w);
        push(exp_edge(w, 2, 1), "R5");
        rd(2'd1, v); chk("R5", v, 32'd2);
        drain();

        // R9: ratio change mid-run applies after the current divided tick
        align(15);
        wr(2'd1, 32'd3, w);
        push(w + 16 + 64, "R9");
        wait_edge(w + 4);
        wr(2'd0, 32'h0, w2);
        drain();

        // R10: pulse gone and count held after expiry
        chk("R10", {31'h0, expire_o}, 32'h0);
        rd(2'd2, v); chk("R10", v, 32'h0);
        repeat (40) @(negedge clk);
        rd(2'd2, v); chk("R10", v, 32'h0);

        if (timeout) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule